// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver

This block sits beside the inbound path of a PCIe root port and turns posted message writes into interrupt status. Each inbound write is offered on a valid/ready stream. A write is claimed as an interrupt message only when three things hold: its 64-bit address equals the programmed doorbell address, its low 16 data bits agree with a programmed pattern under a programmed compare mask, and the receiver is enabled. The data bits that the compare mask leaves open carry the vector number. That vector sets one bit in a status field that may start at a fixed bit offset inside a 32-bit status word.

Software programs the doorbell address, the pattern and the enable through a small word-indexed register port. It reads pending vectors and acknowledges them by writing ones. It can also force vectors pending, and mask or unmask individual vectors. One level-sensitive interrupt line summarises every pending vector that is not masked.

The stream side never stalls. `wr_ready` is high whenever the block is out of reset, and a write is consumed on every cycle where `wr_valid` and `wr_ready` are both high. A source may therefore present a new write on every cycle. Writes that are not claimed are dropped silently.

Top module: `msi_rx_intc`

## Requirements
- R1: After reset the status field is 0, every vector is masked, the address and pattern registers are 0 (receiver disabled), and `irq` is low.
- R2: Bit 0 of register index 0 is the receiver enable. A write is addressed to the receiver only when `wr_addr` equals {index 1, index 0 bits 31:2, 2'b00}, which covers targets both below and above 4 GB.
- R3: Register index 2 holds a compare mask in bits 31:16 and a pattern in bits 15:0. The data agrees when (wr_data[15:0] & mask) == (pattern & mask). wr_data[31:16] is ignored.
- R4: The vector is wr_data[15:0] & ~mask. A claimed message sets status bit BIT_OFS+vector. A vector of NUM_VEC or more is dropped.
- R5: A write that misses the address, fails the data compare, or arrives while the receiver is disabled sets no status bit.
- R6: Writing register index 5 clears every status bit written as 1. Bits written as 0 are unchanged.
- R7: Writing register index 4 sets every status bit written as 1.
- R8: Writing ones to register index 7 masks vectors and writing ones to index 8 unmasks them. Index 6 reads the mask. Mask bits use the same positions as status bits.
- R9: `irq` is high exactly while some status bit is 1 and its mask bit is 0.
- R10: When a claimed message and a clear of the same bit land in the same cycle, the bit ends up set.
- R11: `wr_ready` is high whenever the block is out of reset. A claimed write shows up in status and `irq` on the cycle after the edge that accepts it.
- R12: Reads by index give: 0 the address low word, 1 the address high word, 2 the data config, 3 the status word, 6 the mask word. Indices 4, 5, 7 and 8 read 0, and bits outside BIT_OFS..BIT_OFS+NUM_VEC-1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Inbound write present |
| wr_ready | output | 1 | Block accepts the write |
| wr_addr | input | 64 | Byte address of the inbound write |
| wr_data | input | 32 | Data of the inbound write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt, high while an unmasked vector is pending |

## Verification
The hardest situation to reach is a message and a software clear of the same status bit that land on the same clock edge. The bench gets there with one task that drives the stream write and the register write in the same cycle. It runs this once on the bit that the message targets and once on a different bit, so that both the win of the new event and the normal clear are observed. Every vector is swept under the 8-vector pattern, each with near-miss addresses and data. The out-of-range vector needs the 32-vector mask while the block is built for 8 vectors.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 64;
  localparam int IDX_W  = 4;
  localparam int HALF_W = 16;

  typedef enum logic [IDX_W-1:0] {
    RI_ADDR_LO  = 4'd0,
    RI_ADDR_HI  = 4'd1,
    RI_DATA_CFG = 4'd2,
    RI_STATUS   = 4'd3,
    RI_SET      = 4'd4,
    RI_CLEAR    = 4'd5,
    RI_MASK     = 4'd6,
    RI_MASK_SET = 4'd7,
    RI_MASK_CLR = 4'd8
  } reg_idx_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] addr_lo,
  output logic [REG_W-1:0] addr_hi,
  output logic [REG_W-1:0] data_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo  <= '0;
      addr_hi  <= '0;
      data_cfg <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RI_ADDR_LO:  addr_lo  <= reg_wdata;
        RI_ADDR_HI:  addr_hi  <= reg_wdata;
        RI_DATA_CFG: data_cfg <= reg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_match.sv
module msi_match
  import msi_rx_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  addr_lo,
  input  logic [REG_W-1:0]  addr_hi,
  input  logic [REG_W-1:0]  data_cfg,
  output logic              hit,
  output logic [VEC_W-1:0]  hit_vec
);
  logic [ADDR_W-1:0] target;
  logic [HALF_W-1:0] cmp_mask, pattern, low_data, vec_full;
  logic addr_ok, data_ok, vec_ok, enabled;
  logic unused_bits;

  assign enabled  = addr_lo[0];
  assign target   = {addr_hi, addr_lo[REG_W-1:2], 2'b00};
  assign cmp_mask = data_cfg[REG_W-1:HALF_W];
  assign pattern  = data_cfg[HALF_W-1:0];
  assign low_data = wr_data[HALF_W-1:0];
  assign vec_full = low_data & ~cmp_mask;

  assign addr_ok = (wr_addr == target);
  assign data_ok = ((low_data & cmp_mask) == (pattern & cmp_mask));
  assign vec_ok  = (vec_full < HALF_W'(NUM_VEC));

  assign hit     = wr_fire && enabled && addr_ok && data_ok && vec_ok;
  assign hit_vec = vec_full[VEC_W-1:0];

  assign unused_bits = ^{wr_data[REG_W-1:HALF_W], addr_lo[1]};
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int NUM_VEC = 8,
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [VEC_W-1:0]   hit_vec,
  input  logic [NUM_VEC-1:0] set_bits,
  input  logic [NUM_VEC-1:0] clr_bits,
  input  logic [NUM_VEC-1:0] mset_bits,
  input  logic [NUM_VEC-1:0] mclr_bits,
  output logic [NUM_VEC-1:0] status_q,
  output logic [NUM_VEC-1:0] mask_q
);
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    logic ev;
    assign ev = hit && (hit_vec == VEC_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
        mask_q[i]   <= 1'b1;
      end else begin
        // arriving event or forced set overrides a clear in the same cycle
        status_q[i] <= (status_q[i] & ~clr_bits[i]) | set_bits[i] | ev;
        if (mset_bits[i])      mask_q[i] <= 1'b1;
        else if (mclr_bits[i]) mask_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msi_rx_intc.sv
module msi_rx_intc
  import msi_rx_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int BIT_OFS = 24,
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [63:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic [REG_W-1:0]   addr_lo, addr_hi, data_cfg;
  logic               rx_en, hit, rdy_q;
  logic [VEC_W-1:0]   hit_vec;
  logic [NUM_VEC-1:0] status_q, mask_q, wfield;
  logic [NUM_VEC-1:0] set_bits, clr_bits, mset_bits, mclr_bits;
  logic [REG_W-1:0]   status_word, mask_word;
  logic               unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign wr_ready = rdy_q;
  assign rx_en    = addr_lo[0];

  msi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .data_cfg(data_cfg)
  );

  msi_match #(.NUM_VEC(NUM_VEC)) u_match (
    .wr_fire(wr_valid && wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data_cfg(data_cfg),
    .hit(hit), .hit_vec(hit_vec)
  );

  assign wfield    = reg_wdata[BIT_OFS +: NUM_VEC];
  assign set_bits  = (reg_we && reg_addr == RI_SET)      ? wfield : '0;
  assign clr_bits  = (reg_we && reg_addr == RI_CLEAR)    ? wfield : '0;
  assign mset_bits = (reg_we && reg_addr == RI_MASK_SET) ? wfield : '0;
  assign mclr_bits = (reg_we && reg_addr == RI_MASK_CLR) ? wfield : '0;
  assign unused_wdata = ^reg_wdata;

  msi_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk(clk), .rst_n(rst_n), .hit(hit), .hit_vec(hit_vec),
    .set_bits(set_bits), .clr_bits(clr_bits), .mset_bits(mset_bits),
    .mclr_bits(mclr_bits), .status_q(status_q), .mask_q(mask_q)
  );

  always_comb begin
    status_word = '0;
    mask_word   = '0;
    status_word[BIT_OFS +: NUM_VEC] = status_q;
    mask_word[BIT_OFS +: NUM_VEC]   = mask_q;
  end

  always_comb begin
    case (reg_addr)
      RI_ADDR_LO:  reg_rdata = addr_lo;
      RI_ADDR_HI:  reg_rdata = addr_hi;
      RI_DATA_CFG: reg_rdata = data_cfg;
      RI_STATUS:   reg_rdata = status_word;
      RI_MASK:     reg_rdata = mask_word;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/msi_rx_intc_chk.sv
module msi_rx_intc_chk #(
  parameter int NUM_VEC = 8,
  parameter int BIT_OFS = 24,
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_ready,
  input logic               reg_we,
  input logic [3:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               irq,
  input logic               rx_en,
  input logic               hit,
  input logic [VEC_W-1:0]   hit_vec,
  input logic [NUM_VEC-1:0] status_q,
  input logic [NUM_VEC-1:0] mask_q
);
  assert_hit_sets_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q[$past(hit_vec)]);

  assert_hit_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && reg_we && reg_addr == 4'd5) |=> status_q[$past(hit_vec)]);

  assert_clear_drops_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd5 && !hit) |=>
      ((status_q & $past(reg_wdata[BIT_OFS +: NUM_VEC])) == '0));

  assert_disabled_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !(reg_we && reg_addr == 4'd4)) |=> ((status_q & ~$past(status_q)) == '0));

  assert_all_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  assert_ready_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);
endmodule

bind msi_rx_intc msi_rx_intc_chk #(.NUM_VEC(NUM_VEC), .BIT_OFS(BIT_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .rx_en(rx_en),
  .hit(hit), .hit_vec(hit_vec), .status_q(status_q), .mask_q(mask_q)
);

// File: tb/tb_msi_rx_intc.sv
module tb_msi_rx_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NV  = 8;
  localparam int OFS = 24;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready;
  logic [63:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic reg_we = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [63:0] TGT_LO = 64'h0_FFFF_FFFC;
  localparam logic [63:0] TGT_HI = 64'hF_FFFF_FFFC;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_rx_intc #(.NUM_VEC(NV), .BIT_OFS(OFS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] vbit(int v);
    return 32'h1 << (OFS + v);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle with optional stream write and optional register write
  task automatic step(bit dw, logic [63:0] a, logic [31:0] d,
                      bit dr, logic [3:0] idx, logic [31:0] wd);
    @(negedge clk);
    wr_valid = dw; wr_addr = a; wr_data = d;
    reg_we = dr; reg_addr = idx; reg_wdata = wd;
    @(negedge clk);
    wr_valid = 0; reg_we = 0;
  endtask

  task automatic send(logic [63:0] a, logic [31:0] d);
    step(1, a, d, 0, 4'd0, 32'h0);
  endtask

  task automatic wreg(logic [3:0] idx, logic [31:0] wd);
    step(0, 64'h0, 32'h0, 1, idx, wd);
  endtask

  task automatic rreg(logic [3:0] idx, output logic [31:0] val);
    reg_addr = idx;
    #1 val = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R12 reset state
    rreg(4'd3, rv); check("R1 status", rv, 32'h0);
    rreg(4'd6, rv); check("R1 mask", rv, 32'hFF00_0000);
    rreg(4'd0, rv); check("R1 addr_lo", rv, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R11 ready", {31'b0, wr_ready}, 32'h1);

    wreg(4'd0, 32'hFFFF_FFFD);
    wreg(4'd1, 32'h0);
    wreg(4'd2, 32'hFFF8_6540);
    rreg(4'd0, rv); check("R12 addr_lo read", rv, 32'hFFFF_FFFD);
    rreg(4'd2, rv); check("R12 cfg read", rv, 32'hFFF8_6540);
    rreg(4'd5, rv); check("R12 clear reads 0", rv, 32'h0);

    // masked sweep: R4 mapping, R6 clear semantics, R9 masked irq
    for (int v = 0; v < NV; v++) begin
      send(TGT_LO, 32'h6540 | v);
      rreg(4'd3, rv); check("R4 vector map", rv, vbit(v));
      check("R9 masked no irq", {31'b0, irq}, 32'h0);
      wreg(4'd5, ~vbit(v));
      rreg(4'd3, rv); check("R6 zero bits keep", rv, vbit(v));
      wreg(4'd5, vbit(v));
      rreg(4'd3, rv); check("R6 clear", rv, 32'h0);
    end

    wreg(4'd8, 32'hFFFF_FFFF);
    rreg(4'd6, rv); check("R8 mask clear", rv, 32'h0);

    // unmasked sweep with near misses: R2, R3, R5, R9, R11
    for (int v = 0; v < NV; v++) begin
      send(64'h0_FFFF_FFF8, 32'h6540 | v);
      send(64'h1_FFFF_FFFC, 32'h6540 | v);
      send(TGT_LO, 32'h6D40 | v);
      rreg(4'd3, rv); check("R5 miss ignored", rv, 32'h0);
      check("R9 idle irq", {31'b0, irq}, 32'h0);
      send(TGT_LO, 32'hABCD_6540 | v);
      rreg(4'd3, rv); check("R3 upper data ignored", rv, vbit(v));
      check("R11 irq next cycle", {31'b0, irq}, 32'h1);
      wreg(4'd5, vbit(v));
      check("R9 irq drops", {31'b0, irq}, 32'h0);
    end

    // disabled receiver
    wreg(4'd0, 32'hFFFF_FFFC);
    send(TGT_LO, 32'h6543);
    rreg(4'd3, rv); check("R5 disabled", rv, 32'h0);

    // above 4 GB target
    wreg(4'd1, 32'hF);
    wreg(4'd0, 32'hFFFF_FFFD);
    send(TGT_LO, 32'h6541);
    rreg(4'd3, rv); check("R2 high word mismatch", rv, 32'h0);
    send(TGT_HI, 32'h6541);
    rreg(4'd3, rv); check("R2 above 4GB", rv, vbit(1));
    wreg(4'd5, 32'hFFFF_FFFF);

    // 32-vector pattern: out of range vector dropped
    wreg(4'd2, 32'hFFE0_6540);
    send(TGT_HI, 32'h6549);
    rreg(4'd3, rv); check("R4 out of range", rv, 32'h0);
    send(TGT_HI, 32'h6547);
    rreg(4'd3, rv); check("R4 wide mask hit", rv, vbit(7));
    wreg(4'd5, 32'hFFFF_FFFF);

    // forced set and masking
    wreg(4'd4, vbit(3) | 32'h0000_00FF);
    rreg(4'd3, rv); check("R7 set", rv, vbit(3));
    check("R9 set irq", {31'b0, irq}, 32'h1);
    wreg(4'd7, vbit(3));
    rreg(4'd6, rv); check("R8 mask set", rv, vbit(3));
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    rreg(4'd3, rv); check("R8 status kept", rv, vbit(3));
    wreg(4'd8, vbit(3));
    check("R9 unmask irq", {31'b0, irq}, 32'h1);
    wreg(4'd5, vbit(3));

    // same-cycle event and clear
    send(TGT_HI, 32'h6542);
    step(1, TGT_HI, 32'h6542, 1, 4'd5, vbit(2));
    rreg(4'd3, rv); check("R10 event wins", rv, vbit(2));
    step(1, TGT_HI, 32'h6545, 1, 4'd5, vbit(2));
    rreg(4'd3, rv); check("R10 other bit", rv, vbit(5));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule